// File: doc/BRIEF.md
# Clause-22 PHY Management Controller

This block is a register-mapped master for the two-wire management bus of an Ethernet PHY. Software programs a control register with the management clock divisor and an optional preamble-suppression mode. For a write, it loads a data register. It then writes a command word that names the operation, the PHY address and the register address. The controller raises a busy flag and clocks out one management frame on `mdc`/`mdio_o`. For a read, it releases the line from turnaround onward and shifts in sixteen data bits. When the frame ends it clears busy, and a read's result can be read from the data register in that same cycle.

The register file has four word addresses: 0 is control, 1 is command, 2 is data and 3 is status. The bidirectional data line is split into an output value, an output enable and an input, so that the pad cell stays outside the block.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, status reads 0 (busy bit 0 low), data reads 0, `mdc` and `mdio_oe` are low, and control reads (DEF_DIV-1)<<9 (0x4E00 for the default of 40). `mdc` only rises while busy.
- R2: A command word with bit 15 set starts a read, and one with only bit 14 set starts a write. Bit 15 wins when both are set. Bits 9:5 give the PHY address and bits 4:0 the register address. A word with neither bit 15 nor bit 14 set starts nothing. The command address reads back the last accepted command with bit 15 = read, bit 14 = write, and the two address fields.
- R3: Status bit 0 rises on the clock edge that accepts a command. It stays high for exactly T*P cycles, where T is 64 frame bits (32 with suppression) and P is the MDC period in clocks.
- R4: A frame is 32 ones (left out when control bit 8 is set), then 01, then opcode 10 for a read or 01 for a write, the PHY address MSB first, the register address MSB first, turnaround 10 for a write, and 16 data bits MSB first.
- R5: The MDC period is P = control[15:9]+1 clocks. `mdio_o` and `mdio_oe` change only on a falling MDC edge or at the start of a frame, and they hold while MDC is high.
- R6: During a read, `mdio_oe` is low from the turnaround onward. `mdio_i` is sampled at each rising MDC edge of the 16 data bits, and the data register holds the value once busy clears.
- R7: A command write that arrives while busy is ignored. The frame in flight, its length and the command readback are unchanged.
- R8: A divisor field of 0 acts as 1, giving P = 2.
- R9: When not busy, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
A command write and a frame that is still being shifted can meet in the same cycle. The controller must keep the running frame and drop the new command. The bench provokes this by writing a read command twenty cycles into a write frame. It judges the result by three things: the captured frame bits still match the first command, the total busy time is still T*P, and the command readback still shows the first command. The responder also drives read data on falling MDC edges. Capture is therefore judged against values that the bench changes only between the controller's sampling points.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management controller.
// Assumes a 16-bit register bus and the fixed clause-22 frame layout.
package mdio_pkg;
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_CMD  = 2'd1,
        RA_DATA = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    localparam int CMD_RD_BIT   = 15;
    localparam int CMD_WR_BIT   = 14;
    localparam int PHY_LSB      = 5;
    localparam int REG_LSB      = 0;
    localparam int FLD_W        = 5;
    localparam int CTL_DIV_LSB  = 9;
    localparam int CTL_SUPP_BIT = 8;
    localparam int PRE_LEN      = 32;
    localparam int BODY_LEN     = 32;
    localparam int DATA_W       = 16;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [FLD_W-1:0] phy;
        logic [FLD_W-1:0] rg;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_regs.sv
// Register file: control, command, data and status.
// It accepts a command only when idle and at least one opcode bit is set.
// It assumes DW >= 16 and that the divisor field fits above bit 9.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DW      = 16,
    parameter int DIV_W   = 7,
    parameter int DEF_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output mdio_cmd_t         cmd_nxt,
    output logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_m1,
    output logic              supp
);
    localparam logic [DIV_W-1:0] DEF_M1 = DIV_W'(DEF_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic              supp_q;
    mdio_cmd_t         cmd_q;
    logic [DATA_W-1:0] data_q;
    logic              cmd_wr;
    logic              unused_bits;

    assign unused_bits = ^{wdata[13:10], wdata[7:0]};

    // Decode the next command from the bus and decide whether it is accepted.
    always_comb begin
        cmd_nxt.rd  = wdata[CMD_RD_BIT];
        cmd_nxt.wr  = !wdata[CMD_RD_BIT];
        cmd_nxt.phy = wdata[PHY_LSB +: FLD_W];
        cmd_nxt.rg  = wdata[REG_LSB +: FLD_W];
        cmd_wr      = we && (addr == RA_CMD);
        start       = cmd_wr && !busy && (wdata[CMD_RD_BIT] || wdata[CMD_WR_BIT]);
    end

    // Register storage; read capture has priority over a software data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DEF_M1;
            supp_q <= 1'b0;
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (we && addr == RA_CTRL) begin
                div_q  <= wdata[CTL_DIV_LSB +: DIV_W];
                supp_q <= wdata[CTL_SUPP_BIT];
            end
            if (start) cmd_q <= cmd_nxt;
            if (rd_done) data_q <= rd_data;
            else if (we && addr == RA_DATA) data_q <= wdata[DATA_W-1:0];
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL: begin
                rdata[CTL_DIV_LSB +: DIV_W] = div_q;
                rdata[CTL_SUPP_BIT]         = supp_q;
            end
            RA_CMD: begin
                rdata[CMD_RD_BIT]            = cmd_q.rd;
                rdata[CMD_WR_BIT]            = cmd_q.wr;
                rdata[PHY_LSB +: FLD_W]      = cmd_q.phy;
                rdata[REG_LSB +: FLD_W]      = cmd_q.rg;
            end
            RA_DATA: rdata[DATA_W-1:0] = data_q;
            default: rdata[0] = busy;
        endcase
    end

    assign wr_data = data_q;
    assign div_m1  = div_q;
    assign supp    = supp_q;
endmodule

// File: rtl/mdio_clkdiv.sv
// MDC generator. It latches the divisor at frame start (0 is clamped to 1)
// and runs only while a frame is active. It gives one-cycle strobes for the
// rising and falling MDC edges; MDC is low when idle.
module mdio_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             mdc
);
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;

    // Edge strobes placed at mid-period and end of period.
    always_comb begin
        rise_stb = run && (cnt_q == (lim_q >> 1));
        fall_stb = run && (cnt_q == lim_q);
    end

    // Divisor latch and period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= DIV_W'(1);
            cnt_q <= '0;
        end else begin
            if (start) lim_q <= (div_m1 == '0) ? DIV_W'(1) : div_m1;
            if (!run || cnt_q == lim_q) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
        end
    end

    // MDC level follows the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) mdc_q <= 1'b0;
        else if (fall_stb)  mdc_q <= 1'b0;
        else if (rise_stb)  mdc_q <= 1'b1;
    end

    assign mdc = mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
// Frame shifter. It latches the frame at start and advances one bit on each
// MDC falling strobe. For a read it releases the line from turnaround and
// samples data on rising strobes. It assumes start never arrives while busy.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd_in,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              supp_in,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(PRE_LEN + BODY_LEN);
    localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(14);
    localparam logic [IDX_W-1:0] DAT_IDX   = IDX_W'(16);
    localparam logic [IDX_W-1:0] PRE_IDX   = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] LAST_SUPP = IDX_W'(BODY_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(PRE_LEN + BODY_LEN - 1);

    logic                busy_q, rd_q, supp_q;
    logic [BODY_LEN-1:0] frame_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_W-1:0]   rx_q;
    logic                in_pre, last, released, cur_bit;
    logic [IDX_W-1:0]    body_j;
    logic [4:0]          jb;

    // Position decode within the frame.
    always_comb begin
        in_pre   = !supp_q && (idx_q < PRE_IDX);
        body_j   = supp_q ? idx_q : idx_q - PRE_IDX;
        jb       = body_j[4:0];
        last     = idx_q == (supp_q ? LAST_SUPP : LAST_FULL);
        cur_bit  = in_pre ? 1'b1 : frame_q[~jb];
        released = rd_q && !in_pre && (body_j >= TA_IDX);
    end

    // Pad-side outputs and read completion.
    always_comb begin
        mdio_o  = busy_q ? cur_bit : 1'b1;
        mdio_oe = busy_q && !released;
        rd_done = busy_q && fall_stb && last && rd_q;
        rd_data = rx_q;
        busy    = busy_q;
    end

    // Frame sequencing and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            supp_q  <= 1'b0;
            frame_q <= '0;
            idx_q   <= '0;
            rx_q    <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            rd_q    <= cmd_in.rd;
            supp_q  <= supp_in;
            idx_q   <= '0;
            rx_q    <= '0;
            frame_q <= {2'b01, (cmd_in.rd ? 2'b10 : 2'b01), cmd_in.phy, cmd_in.rg,
                        (cmd_in.rd ? 2'b11 : 2'b10),
                        (cmd_in.rd ? {DATA_W{1'b0}} : wr_data)};
        end else if (busy_q) begin
            if (fall_stb) begin
                if (last) busy_q <= 1'b0;
                else      idx_q  <= idx_q + 1'b1;
            end
            if (rise_stb && rd_q && !in_pre && body_j >= DAT_IDX)
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_ctrl.sv
// Top of the management controller: register file, MDC divider and frame
// shifter. The data line is split into value, enable and input.
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int DW      = 16,
    parameter int DIV_W   = 7,
    parameter int DEF_DIV = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    logic              busy, start, rd_done, supp, rise_stb, fall_stb;
    mdio_cmd_t         cmd_nxt;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [DIV_W-1:0]  div_m1;

    mdio_regs #(.DW(DW), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
        .rd_done(rd_done), .rd_data(rd_data), .start(start),
        .cmd_nxt(cmd_nxt), .wr_data(wr_data), .div_m1(div_m1), .supp(supp)
    );

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
        .div_m1(div_m1), .rise_stb(rise_stb), .fall_stb(fall_stb), .mdc(mdc)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_nxt),
        .wr_data(wr_data), .supp_in(supp), .rise_stb(rise_stb),
        .fall_stb(fall_stb), .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_done(rd_done), .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_ctrl_chk.sv
// Protocol checker bound to the controller top.
module mdio_ctrl_chk
    import mdio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       busy,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe
);
    // R5
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(reg_we) && $past(reg_addr) == RA_CMD));

    // R1
    mdc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdio_oe) |=> (!mdio_oe || !busy));
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_ctrl.sv
// Directed bench with a simple PHY responder.
module tb_mdio_ctrl;
    import mdio_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, mdio_i = 1'b1;
    logic [1:0]  reg_addr = RA_STAT;
    logic [15:0] reg_wdata = '0;
    wire  [15:0] reg_rdata;
    wire         mdc, mdio_o, mdio_oe;

    int n_chk = 0, n_fail = 0, cyc = 0, ncap = 0;
    logic cap_o [64];
    logic cap_oe[64];
    int   rise_t[64];
    logic        resp_supp = 1'b0;
    logic [15:0] resp_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY responder: record each rising MDC, drive read data after falling MDC.
    always @(posedge mdc) begin
        if (ncap < 64) begin
            cap_o[ncap] = mdio_o; cap_oe[ncap] = mdio_oe; rise_t[ncap] = cyc;
        end
        ncap = ncap + 1;
    end
    always @(negedge mdc) begin
        int j;
        j = resp_supp ? ncap : ncap - 32;
        mdio_i = (j >= 16 && j < 32) ? resp_val[31-j] : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(int n, logic supp, logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        logic [31:0] f;
        int j;
        f = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
        if (!supp && n < 32) return 1'b1;
        j = supp ? n : n - 32;
        return f[31-j];
    endfunction

    function automatic logic exp_oe(int n, logic supp, logic rd);
        int j;
        if (!supp && n < 32) return 1'b1;
        j = supp ? n : n - 32;
        return !(rd && j >= 14);
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0; reg_addr = RA_STAT;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0; reg_addr = RA_STAT; #1;
        while (reg_rdata[0] && cnt < 20000) begin
            cnt++; @(negedge clk); #1;
        end
    endtask

    task automatic check_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] d, input logic supp, input string req);
        int t, bad;
        t = supp ? 32 : 64; bad = -1;
        chk(ncap == t, {req, " bit count"}, ncap, t);
        for (int n = 0; n < t && n < 64; n++) begin
            if (bad < 0 && (cap_oe[n] !== exp_oe(n, supp, rd) ||
                (exp_oe(n, supp, rd) && cap_o[n] !== exp_bit(n, supp, rd, phy, rg, d))))
                bad = n;
        end
        chk(bad < 0, {req, " first bad bit"}, bad, 32'hFFFFFFFF);
    endtask

    task automatic run_frame(input logic rd, input logic both, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] d, input logic supp, input logic [6:0] divf, input string req);
        int p, t, cnt;
        logic [15:0] v;
        p = (divf == 0) ? 2 : divf + 1;
        t = supp ? 32 : 64;
        wr_reg(RA_CTRL, {divf, supp, 8'h00});
        resp_supp = supp; resp_val = d;
        if (!rd) wr_reg(RA_DATA, d);
        ncap = 0;
        wr_reg(RA_CMD, {(rd | both), (both | !rd), 4'b0, phy, rg});
        wait_idle(cnt);
        chk(cnt == t * p, {req, " R3 busy length"}, cnt, t * p);
        check_frame(rd | both, phy, rg, d, supp, {req, " R4 frame"});
        chk(!mdc && !mdio_oe, {req, " R9 idle"}, {mdc, mdio_oe}, 0);
        if (ncap >= 2) chk(rise_t[1] - rise_t[0] == p, {req, " R5 period"}, rise_t[1] - rise_t[0], p);
        rd_reg(RA_CMD, v);
        chk(v == {(rd | both), !(rd | both), 4'b0, phy, rg}, {req, " R2 readback"}, v,
            {(rd | both), !(rd | both), 4'b0, phy, rg});
        if (rd | both) begin
            rd_reg(RA_DATA, v);
            chk(v == d, {req, " R6 read data"}, v, d);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd_reg(RA_CTRL, v); chk(v == 16'h4E00, "R1 ctrl reset", v, 16'h4E00);
        rd_reg(RA_STAT, v); chk(v == 16'h0, "R1 status reset", v, 0);
        rd_reg(RA_DATA, v); chk(v == 16'h0, "R1 data reset", v, 0);
        chk(!mdc && !mdio_oe, "R1 pins idle", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_no_op;
        logic [15:0] v;
        ncap = 0;
        wr_reg(RA_CMD, 16'h0123);
        repeat (20) @(negedge clk);
        rd_reg(RA_STAT, v);
        chk(v == 16'h0 && ncap == 0, "R2 no opcode bit", {v, 16'(ncap)}, 0);
    endtask

    task automatic t_busy_cmd;
        int cnt;
        logic [15:0] v;
        wr_reg(RA_CTRL, {7'd3, 1'b0, 8'h00});
        wr_reg(RA_DATA, 16'h1234);
        resp_supp = 1'b0; ncap = 0;
        wr_reg(RA_CMD, {2'b01, 4'b0, 5'd2, 5'd3});
        repeat (20) @(negedge clk);
        wr_reg(RA_CMD, {2'b10, 4'b0, 5'd7, 5'd9});
        wait_idle(cnt);
        chk(cnt + 22 == 256, "R7 busy length", cnt + 22, 256);
        check_frame(1'b0, 5'd2, 5'd3, 16'h1234, 1'b0, "R7 frame");
        rd_reg(RA_CMD, v);
        chk(v == {2'b01, 4'b0, 5'd2, 5'd3}, "R7 readback", v, {2'b01, 4'b0, 5'd2, 5'd3});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_frame(1'b0, 1'b0, 5'h11, 5'h0A, 16'hA5C3, 1'b0, 7'd3, "R2 write");
        run_frame(1'b1, 1'b0, 5'h1F, 5'h01, 16'h3C5A, 1'b0, 7'd3, "R6 read");
        run_frame(1'b1, 1'b0, 5'h00, 5'h1E, 16'hF00F, 1'b1, 7'd2, "R4 suppressed");
        run_frame(1'b0, 1'b0, 5'h0C, 5'h15, 16'h8001, 1'b1, 7'd0, "R8 min divisor");
        run_frame(1'b0, 1'b1, 5'h05, 5'h10, 16'h6E29, 1'b0, 7'd1, "R2 both bits");
        t_no_op();
        t_busy_cmd();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule